// File: doc/BRIEF.md
# Serial Configuration Loader with Rate Switch

This block is the clock-driving side of a serial configuration load. A start pulse makes it begin a load. It then holds the external serial memory in reset for a short, fixed time. After that it produces a configuration clock by dividing the system clock, and on each rising edge of that clock it takes in one data bit. It collects the bits into bytes, most significant bit first, and writes each byte into an internal store. The store can be read back through a synchronous read port.

The configuration clock begins at a slow startup rate. One byte at a fixed position in the stream carries a 3-bit rate code. Once that byte has been assembled, the divider changes to the rate that the code selects. The change happens only at a falling edge of the configuration clock, so no shortened pulse is produced. When the full frame has been stored, the block raises its done flag and drops the memory enable. From then on, every further bit it samples is passed to the daisy-chain output.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the outputs `cfg_clk`, `mem_rst`, `mem_ce`, `done` and `dout` are all low.
- R2: A start pulse is accepted only in the idle state and only when `mode[0]` and `mode[1]` are both 0. `mode[2]` has no effect. A start pulse under any other mode value leaves all outputs idle and produces no configuration clock edge.
- R3: After an accepted start, `mem_ce` rises and `mem_rst` stays high for exactly INIT_CYC system cycles. `cfg_clk` stays low for as long as `mem_rst` is high.
- R4: Up to and including the rising edge that completes byte RATE_BYTE, the configuration clock period is 2*SLOW_HALF system cycles. No clock phase ever lasts longer than SLOW_HALF+1 cycles.
- R5: Exactly one `din` bit is taken on each rising edge of `cfg_clk`. The first bit of each byte is its bit 7. Byte n of the stream (counted from 0) is written to store address n.
- R6: The rate code is bits [RATE_LSB+2:RATE_LSB] of byte RATE_BYTE; the other bits of that byte are ignored. The new half period is DEF_HALF shifted right by the code, with a minimum of 1. It takes effect at the first falling edge after that byte is complete, so the next clock period is SLOW_HALF plus the new half period. Every period after that is twice the new half period.
- R7: When byte FRAME_BYTES-1 has been stored, `done` rises and stays high until reset, and `mem_ce` falls. `done` and `mem_ce` are never high together.
- R8: `dout` is 0 until `done` is high. After that, on each rising `cfg_clk` edge, `dout` takes the `din` bit sampled at that edge. Bits that belong to the frame never appear on `dout`.
- R9: `rd_data` returns the store byte at `rd_addr` one system cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Mode select; bits 1:0 must be 00 for a load to start |
| start | input | 1 | Start pulse for a load |
| din | input | 1 | Serial data from the memory |
| cfg_clk | output | 1 | Configuration clock to the memory |
| mem_rst | output | 1 | Reset to the serial memory |
| mem_ce | output | 1 | Chip enable to the serial memory |
| done | output | 1 | Frame fully loaded |
| dout | output | 1 | Daisy-chain serial output |
| rd_addr | input | $clog2(FRAME_BYTES) | Store read address |
| rd_data | output | 8 | Store read data |

## Verification
The rate switch and the final byte write can both land close to a clock edge. The bench watches the cycle at which the rate byte completes: the new divider is requested one cycle after that rising edge, but it may only act at the following falling edge. The bench records the system cycle of every rising edge and checks three things: the period across the switch, the periods on either side of it, and that the store contents remain correct. The last frame bit also coincides with the raising of `done` and the start of forwarding. This is judged by requiring `dout` to stay 0 for that last frame bit and to carry the stream bits exactly from the next one onward.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_LOAD  = 2'd2,
    ST_CHAIN = 2'd3
  } ld_state_t;

  // Half period (in system cycles) chosen by a rate code.
  function automatic int unsigned rate_half(input logic [2:0] code,
                                            input int unsigned def_half);
    int unsigned h;
    h = def_half >> code;
    if (h == 0) h = 1;
    return h;
  endfunction

endpackage

// File: rtl/cfgld_clkgen.sv
module cfgld_clkgen #(
  parameter int SLOW_HALF = 10,
  parameter int HALF_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              req_valid,
  input  logic [HALF_W-1:0] req_half,
  output logic              cclk_o,
  output logic              rise_o
);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_act;
  logic [HALF_W-1:0] half_pend;
  logic              pend;
  logic              cclk;
  logic              last;

  assign last   = (cnt == half_act - 1'b1);
  assign rise_o = run && !cclk && last;
  assign cclk_o = cclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt       <= '0;
      cclk      <= 1'b0;
      half_act  <= HALF_W'(SLOW_HALF);
      half_pend <= '0;
      pend      <= 1'b0;
    end else begin
      if (last) begin
        cnt  <= '0;
        cclk <= ~cclk;
        // new divider only applies as a low phase begins
        if (cclk && pend) begin
          half_act <= half_pend;
          pend     <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (req_valid) begin
        half_pend <= req_half;
        pend      <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_en,
  input  logic              din,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  idx_o
);

  localparam int BITS_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] sh;
  logic [BITS_W-1:0] bitc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh           <= '0;
      bitc         <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      idx_o        <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (byte_valid_o) idx_o <= idx_o + 1'b1;
      if (bit_en) begin
        sh   <= {sh[BYTE_W-3:0], din};
        bitc <= bitc + 1'b1;
        if (bitc == BITS_W'(BYTE_W - 1)) begin
          byte_o       <= {sh, din};
          byte_valid_o <= 1'b1;
          bitc         <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/cfgld_store.sv
module cfgld_store #(
  parameter int DEPTH  = 64,
  parameter int BYTE_W = 8,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int FRAME_BYTES = 64,
  parameter int RATE_BYTE   = 60,
  parameter int RATE_LSB    = 0,
  parameter int SLOW_HALF   = 10,
  parameter int DEF_HALF    = 6,
  parameter int INIT_CYC    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [2:0]                     mode,
  input  logic                           start,
  input  logic                           din,
  output logic                           cfg_clk,
  output logic                           mem_rst,
  output logic                           mem_ce,
  output logic                           done,
  output logic                           dout,
  input  logic [$clog2(FRAME_BYTES)-1:0] rd_addr,
  output logic [7:0]                     rd_data
);
  import cfgld_pkg::*;

  localparam int BYTE_W = 8;
  localparam int AW     = $clog2(FRAME_BYTES);
  localparam int CNT_W  = $clog2(FRAME_BYTES + 1);
  localparam int MAXH   = (SLOW_HALF > DEF_HALF) ? SLOW_HALF : DEF_HALF;
  localparam int HALF_W = $clog2(MAXH + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);

  ld_state_t         state;
  logic [INIT_W-1:0] init_cnt;
  logic              accept, run, rise, bit_en;
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;
  logic [CNT_W-1:0]  byte_idx;
  logic              rate_req, last_byte;
  logic [HALF_W-1:0] rate_half_q;
  logic              unused_mode;

  assign unused_mode = mode[2];
  assign accept    = (state == ST_IDLE) && start && (mode[1:0] == 2'b00);
  assign run       = (state == ST_LOAD) || (state == ST_CHAIN);
  assign bit_en    = rise && (state == ST_LOAD);
  assign rate_req  = byte_valid && (byte_idx == CNT_W'(RATE_BYTE));
  assign last_byte = byte_valid && (byte_idx == CNT_W'(FRAME_BYTES - 1));
  assign rate_half_q = HALF_W'(rate_half(byte_data[RATE_LSB +: 3], DEF_HALF));

  cfgld_clkgen #(.SLOW_HALF(SLOW_HALF), .HALF_W(HALF_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(run),
    .req_valid(rate_req), .req_half(rate_half_q),
    .cclk_o(cfg_clk), .rise_o(rise)
  );

  cfgld_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shifter (
    .clk(clk), .rst(rst), .clr(accept), .bit_en(bit_en), .din(din),
    .byte_valid_o(byte_valid), .byte_o(byte_data), .idx_o(byte_idx)
  );

  cfgld_store #(.DEPTH(FRAME_BYTES), .BYTE_W(BYTE_W), .AW(AW)) u_store (
    .clk(clk), .we(byte_valid && (state == ST_LOAD)),
    .waddr(byte_idx[AW-1:0]), .wdata(byte_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      init_cnt <= '0;
      mem_rst  <= 1'b0;
      mem_ce   <= 1'b0;
      done     <= 1'b0;
      dout     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_INIT;
            mem_rst  <= 1'b1;
            mem_ce   <= 1'b1;
            init_cnt <= '0;
          end
        end
        ST_INIT: begin
          if (init_cnt == INIT_W'(INIT_CYC - 1)) begin
            mem_rst <= 1'b0;
            state   <= ST_LOAD;
          end else begin
            init_cnt <= init_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (last_byte) begin
            done   <= 1'b1;
            mem_ce <= 1'b0;
            state  <= ST_CHAIN;
          end
        end
        ST_CHAIN: begin
          if (rise) dout <= din;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int SLOW_HALF = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       start,
  input logic       cfg_clk,
  input logic       mem_rst,
  input logic       mem_ce,
  input logic       done,
  input logic       dout
);

  logic [15:0] plen;
  logic        cclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      plen   <= '0;
      cclk_q <= 1'b0;
    end else begin
      cclk_q <= cfg_clk;
      if (mem_rst || (!mem_ce && !done)) plen <= '0;
      else if (cfg_clk != cclk_q)        plen <= 16'd1;
      else if (plen != 16'hFFFF)         plen <= plen + 1'b1;
    end
  end

  AST_CE_OFF_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_ce); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> done); // R7
  AST_CLK_LOW_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    mem_rst |-> !cfg_clk); // R3
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done |-> !dout); // R8
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce) |-> ($past(start) && ($past(mode[1:0]) == 2'b00))); // R2
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cfg_clk != cclk_q) |-> (plen <= 16'(SLOW_HALF + 1))); // R4

endmodule

bind cfg_serial_loader cfgld_checker #(.SLOW_HALF(SLOW_HALF)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .start(start), .cfg_clk(cfg_clk),
  .mem_rst(mem_rst), .mem_ce(mem_ce), .done(done), .dout(dout)
);

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME  = 64;
  localparam int RATE_B = 60;
  localparam int SLOW   = 10;
  localparam int DEFH   = 6;
  localparam int INITC  = 4;
  localparam int NB     = FRAME + 8;
  localparam int NBITS  = NB * 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       start = 1'b0;
  logic       din;
  logic       cfg_clk, mem_rst, mem_ce, done, dout;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ptr = 0;
  int nrise = 0;
  int dout_bad = 0;
  int dout_seen = 0;
  bit mon_en = 1'b0;
  logic [7:0] stream [NB];
  int rise_t [NBITS];

  cfg_serial_loader dut (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .din(din),
    .cfg_clk(cfg_clk), .mem_rst(mem_rst), .mem_ce(mem_ce), .done(done),
    .dout(dout), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic bit_at(input int p);
    if (p < 0 || p >= NBITS) return 1'b0;
    return stream[p/8][7-(p%8)];
  endfunction

  always_comb din = bit_at(ptr);

  // serial memory model: next bit after each rising configuration clock
  always @(posedge cfg_clk) begin
    if (ptr < NBITS) rise_t[ptr] = cyc;
    nrise = nrise + 1;
    #1 ptr = ptr + 1;
  end

  always @(negedge cfg_clk) begin
    if (mon_en) begin
      logic e;
      e = (ptr - 1 >= FRAME*8) ? bit_at(ptr - 1) : 1'b0;
      if (dout !== e) dout_bad = dout_bad + 1;
      dout_seen = dout_seen + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!cfg_clk && !mem_rst && !mem_ce && !done && !dout, "R1 idle outputs",
        {cfg_clk, mem_rst, mem_ce, done, dout}, 0);
  endtask

  task automatic t_mode_ignored();
    logic [2:0] bad [3] = '{3'b001, 3'b010, 3'b111};
    do_reset();
    nrise = 0;
    foreach (bad[i]) begin
      mode = bad[i]; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      chk(!mem_ce && !mem_rst && nrise == 0, "R2 start ignored for mode",
          {mem_ce, mem_rst, 8'(nrise)}, 0);
    end
  endtask

  task automatic t_load(input logic [2:0] code, input logic [2:0] md);
    int h, rst_len, bad_p, k0, mism, wait_c;
    h = DEFH >> code; if (h == 0) h = 1;
    for (int i = 0; i < NB; i++)
      stream[i] = (i == RATE_B) ? {5'b10110, code} : 8'(i*53 + 17);
    do_reset();
    ptr = 0; nrise = 0; dout_bad = 0; dout_seen = 0; mon_en = 1'b1;
    mode = md; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(mem_rst && mem_ce && !cfg_clk, "R3 memory reset on start", {mem_rst, mem_ce, cfg_clk}, 6);
    rst_len = 0;
    while (mem_rst && rst_len < 100) begin
      rst_len++;
      if (cfg_clk) chk(0, "R3 clock low during reset", 1, 0);
      @(negedge clk);
    end
    chk(rst_len == INITC, "R3 reset length", rst_len, INITC);
    wait_c = 0;
    while (!done && wait_c < 30000) begin @(negedge clk); wait_c++; end
    chk(done && !mem_ce, "R7 done raised, enable dropped", {done, mem_ce}, 2);
    chk(nrise == FRAME*8, "R5 one bit per edge at done", nrise, FRAME*8);
    wait_c = 0;
    while (ptr < NBITS && wait_c < 5000) begin @(negedge clk); wait_c++; end
    @(negedge clk);
    mon_en = 1'b0;
    chk(done, "R7 done holds", done, 1);
    chk(dout_bad == 0 && dout_seen > 0, "R8 daisy-chain bits", dout_bad, 0);
    bad_p = 0;
    k0 = (RATE_B + 1) * 8;
    for (int k = 1; k < k0; k++)
      if (rise_t[k] - rise_t[k-1] != 2*SLOW) bad_p++;
    chk(bad_p == 0, "R4 startup periods", bad_p, 0);
    chk(rise_t[k0] - rise_t[k0-1] == SLOW + h, "R6 switch period",
        rise_t[k0] - rise_t[k0-1], SLOW + h);
    chk(rise_t[k0+1] - rise_t[k0] == 2*h, "R6 new period",
        rise_t[k0+1] - rise_t[k0], 2*h);
    chk(rise_t[k0+20] - rise_t[k0+19] == 2*h, "R6 new period later",
        rise_t[k0+20] - rise_t[k0+19], 2*h);
    mism = 0;
    for (int a = 0; a < FRAME; a++) begin
      rd_addr = 6'(a);
      @(negedge clk);
      if (rd_data !== stream[a]) mism++;
      if (a == 0) chk(rd_data === stream[0], "R9 read byte 0 MSB first", rd_data, stream[0]);
      if (a == RATE_B) chk(rd_data === stream[RATE_B], "R5 rate byte stored", rd_data, stream[RATE_B]);
    end
    chk(mism == 0, "R5 store contents", mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mode_ignored();
    t_load(3'd2, 3'b000);
    t_load(3'd1, 3'b100);
    t_load(3'd0, 3'b000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule